// File: doc/BRIEF.md
# Shifter Operand Generator with Carry

This block forms the second ALU operand and the shifter carry-out for a 32-bit processor datapath. It takes the low twelve bits of the instruction, a flag that selects the rotated-constant form, the operand register value, the low byte of the amount register and the current carry flag. It returns the shaped operand and the carry that the flag logic uses for logical operations. Register file reads and the ALU are outside the block.

Three forms are handled. In the first, a register is shifted by a 5-bit constant from the instruction. In the second, the register is shifted by a byte-sized amount taken from another register. In the third, an 8-bit constant is rotated right by an even distance. Zero and oversized amounts follow fixed rules, listed below. All shifting is done in one cycle by a logarithmic barrel network, and the result is held in an output register that loads only while `en` is high.

Top module: `shifter_operand_gen`

## Requirements
- R1: While `rst_n` is low, `op_out` is 0 and `c_out` is 0, whatever the other inputs. For two rising edges after `rst_n` rises, the outputs stay at 0.
- R2: A result appears on `op_out` and `c_out` after the rising edge at which `en` was high. When `en` is low, the outputs keep their values regardless of any input.
- R3: The form is selected as follows. `rot_imm`=1 selects the rotated constant. Otherwise `instr[4]`=1 selects the register amount (`rs_low`). Otherwise the amount comes from `instr[11:7]`. `instr[6:5]` picks the operation: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. For a constant amount n in 1..31, the value is `rm_val` shifted by n, and `c_out` is the last bit shifted out.
- R4: With the constant-amount form and `instr[11:7]`=0: a left shift passes `rm_val` and `c_in` through. A logical right shift gives 0 with `c_out` = bit 31. An arithmetic right shift fills every bit with bit 31, and `c_out` = bit 31.
- R5: With the constant-amount form, `instr[11:7]`=0 and operation 3, the block performs a one-bit rotate through carry. The result is `{c_in, rm_val[31:1]}` and `c_out` = `rm_val[0]`.
- R6: With the register-amount form, logical shifts work as follows. An amount of 0 passes the value and `c_in` through, and 1..31 shifts normally. An amount of 32 gives 0, with `c_out` = bit 0 for a left shift and bit 31 for a right shift. Amounts from 33 to 255 give 0 with `c_out` = 0.
- R7: With the register-amount form and an arithmetic right shift, amounts from 32 to 255 give all bits equal to `rm_val[31]`, and `c_out` equals that bit.
- R8: With the register-amount form and a rotate, an amount of 0 passes the value and `c_in` through. A nonzero amount whose low 5 bits are 0 leaves the value unchanged and sets `c_out` to bit 31. Any other amount rotates by its low 5 bits, and `c_out` is bit 31 of the result.
- R9: With `rot_imm`=1, the block zero-extends `instr[7:0]` and rotates it right by twice `instr[11:8]`. If `instr[11:8]` is nonzero, `c_out` is bit 31 of the result. If it is zero, `c_out` is `c_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| en | input | 1 | Load enable of the output register |
| rot_imm | input | 1 | Selects the rotated 8-bit constant form |
| instr | input | 12 | Instruction bits 11:0 (amount, operation, form bit, constant) |
| rm_val | input | DATA_W | Value of the operand register |
| rs_low | input | 8 | Low byte of the amount register |
| c_in | input | 1 | Current carry flag |
| op_out | output | DATA_W | Shaped operand |
| c_out | output | 1 | Shifter carry-out |

## Verification
The bench builds the block with its default `DATA_W` of 32, which is the width the instruction encoding assumes. At that width the 8-bit register amount reaches every class the rules distinguish. These are zero, 1..31, exactly 32, 33..255, and nonzero multiples of 32 for the rotate, so the saturation boundaries at 31/32/33 and the rotate-by-32 case are hit directly. The rotated-constant form covers even distances from 0 to 30. Together with the all-zero constant amount, this exercises every special case of the three forms.

// File: rtl/sop_pkg.sv
package sop_pkg;
  // instruction slice seen by the block
  localparam int INSTR_W   = 12;
  localparam int FORM_BIT  = 4;
  localparam int MODE_LO   = 5;
  localparam int AMT_LO    = 7;
  localparam int IMM_AMT_W = INSTR_W - AMT_LO;
  localparam int ROT_LO    = 8;
  localparam int ROT_W     = INSTR_W - ROT_LO;
  localparam int IMM8_W    = 8;
  localparam int RS_W      = 8;

  typedef enum logic [1:0] {
    SM_LSL = 2'd0,
    SM_LSR = 2'd1,
    SM_ASR = 2'd2,
    SM_ROR = 2'd3
  } smode_e;

  typedef enum logic [2:0] {
    SK_PASS,
    SK_LSL,
    SK_LSR,
    SK_ASR,
    SK_ROR,
    SK_RRX
  } shk_e;

  typedef enum logic [1:0] {
    SC_NORM,
    SC_FULL,
    SC_OVER
  } shc_e;

  function automatic shk_e mode_kind(input logic [1:0] m);
    case (m)
      SM_LSL:  return SK_LSL;
      SM_LSR:  return SK_LSR;
      SM_ASR:  return SK_ASR;
      default: return SK_ROR;
    endcase
  endfunction
endpackage

// File: rtl/sop_decode.sv
module sop_decode
  import sop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                       rot_imm,
  input  logic [INSTR_W-1:0]         instr,
  input  logic [DATA_W-1:0]          rm_val,
  input  logic [RS_W-1:0]            rs_low,
  output logic [DATA_W-1:0]          src,
  output shk_e                       kind,
  output shc_e                       cls,
  output logic [$clog2(DATA_W)-1:0]  amt
);
  localparam int AMT_W = $clog2(DATA_W);
  localparam logic [RS_W-1:0] W_RS = RS_W'(DATA_W);

  logic [1:0]           mode;
  logic [IMM_AMT_W-1:0] imm_amt;
  logic [ROT_W-1:0]     rot;
  logic [IMM8_W-1:0]    imm8;
  logic [AMT_W-1:0]     rs_part;

  assign mode    = instr[MODE_LO +: 2];
  assign imm_amt = instr[AMT_LO +: IMM_AMT_W];
  assign rot     = instr[ROT_LO +: ROT_W];
  assign imm8    = instr[IMM8_W-1:0];
  assign rs_part = rs_low[AMT_W-1:0];

  // constant-amount form
  shk_e             k_i;
  shc_e             c_i;
  logic [AMT_W-1:0] a_i;
  always_comb begin
    k_i = mode_kind(mode);
    c_i = SC_NORM;
    a_i = AMT_W'(imm_amt);
    if (imm_amt == '0) begin
      case (mode)
        SM_LSL:  k_i = SK_PASS;
        SM_LSR:  c_i = SC_FULL;
        SM_ASR:  c_i = SC_FULL;
        default: k_i = SK_RRX;
      endcase
    end
  end

  // register-amount form
  shk_e             k_r;
  shc_e             c_r;
  logic [AMT_W-1:0] a_r;
  always_comb begin
    k_r = mode_kind(mode);
    c_r = SC_NORM;
    a_r = rs_part;
    if (rs_low == '0) begin
      k_r = SK_PASS;
    end else begin
      case (mode)
        SM_LSL, SM_LSR: begin
          if (rs_low == W_RS)     c_r = SC_FULL;
          else if (rs_low > W_RS) c_r = SC_OVER;
        end
        SM_ASR: begin
          if (rs_low >= W_RS) c_r = SC_FULL;
        end
        default: begin
          if (rs_part == '0) c_r = SC_FULL;
        end
      endcase
    end
  end

  // rotated-constant form
  shk_e             k_c;
  logic [AMT_W-1:0] a_c;
  always_comb begin
    a_c = AMT_W'({rot, 1'b0});
    k_c = (rot == '0) ? SK_PASS : SK_ROR;
  end

  // form select
  always_comb begin
    if (rot_imm) begin
      src  = {{(DATA_W-IMM8_W){1'b0}}, imm8};
      kind = k_c;
      cls  = SC_NORM;
      amt  = a_c;
    end else if (instr[FORM_BIT]) begin
      src  = rm_val;
      kind = k_r;
      cls  = c_r;
      amt  = a_r;
    end else begin
      src  = rm_val;
      kind = k_i;
      cls  = c_i;
      amt  = a_i;
    end
  end
endmodule

// File: rtl/sop_barrel.sv
module sop_barrel #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]          din,
  input  logic [$clog2(DATA_W)-1:0]  amt,
  input  logic                       rotate,
  input  logic                       fill,
  output logic [DATA_W-1:0]          dout
);
  localparam int AMT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] stg [0:AMT_W];
  assign stg[0] = din;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int STEP = 2 ** s;
    logic [STEP-1:0] hi;
    assign hi = rotate ? stg[s][STEP-1:0] : {STEP{fill}};
    assign stg[s+1] = amt[s] ? {hi, stg[s][DATA_W-1:STEP]} : stg[s];
  end

  assign dout = stg[AMT_W];
endmodule

// File: rtl/sop_shift_unit.sv
module sop_shift_unit
  import sop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]          src,
  input  logic                       c_in,
  input  shk_e                       kind,
  input  shc_e                       cls,
  input  logic [$clog2(DATA_W)-1:0]  amt,
  output logic [DATA_W-1:0]          val,
  output logic                       cout
);
  localparam int AMT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] rev_src, orient, bar_out, rev_out, shifted;
  logic [AMT_W-1:0]  amt_m1;
  logic              lost;
  logic              is_left;

  assign is_left = (kind == SK_LSL);

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      rev_src[i] = src[DATA_W-1-i];
      rev_out[i] = bar_out[DATA_W-1-i];
    end
  end

  // left shifts run through the right-shifting network bit-reversed
  assign orient = is_left ? rev_src : src;

  sop_barrel #(.DATA_W(DATA_W)) u_barrel (
    .din    (orient),
    .amt    (amt),
    .rotate (kind == SK_ROR),
    .fill   ((kind == SK_ASR) && src[DATA_W-1]),
    .dout   (bar_out)
  );

  assign shifted = is_left ? rev_out : bar_out;
  assign amt_m1  = amt - AMT_W'(1);
  assign lost    = orient[amt_m1];

  always_comb begin
    val  = src;
    cout = c_in;
    case (kind)
      SK_PASS: begin
        val  = src;
        cout = c_in;
      end
      SK_RRX: begin
        val  = {c_in, src[DATA_W-1:1]};
        cout = src[0];
      end
      SK_ROR: begin
        val  = shifted;
        cout = shifted[DATA_W-1];
      end
      SK_LSL, SK_LSR, SK_ASR: begin
        case (cls)
          SC_NORM: begin
            val  = shifted;
            cout = lost;
          end
          SC_FULL: begin
            if (kind == SK_ASR) begin
              val  = {DATA_W{src[DATA_W-1]}};
              cout = src[DATA_W-1];
            end else begin
              val  = '0;
              cout = is_left ? src[0] : src[DATA_W-1];
            end
          end
          default: begin
            val  = '0;
            cout = 1'b0;
          end
        endcase
      end
      default: begin
        val  = src;
        cout = c_in;
      end
    endcase
  end
endmodule

// File: rtl/shifter_operand_gen.sv
module shifter_operand_gen
  import sop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 rot_imm,
  input  logic [11:0]          instr,
  input  logic [DATA_W-1:0]    rm_val,
  input  logic [7:0]           rs_low,
  input  logic                 c_in,
  output logic [DATA_W-1:0]    op_out,
  output logic                 c_out
);
  localparam int AMT_W = $clog2(DATA_W);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [DATA_W-1:0] src;
  shk_e              kind;
  shc_e              cls;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] unit_val;
  logic              unit_c;

  sop_decode #(.DATA_W(DATA_W)) u_decode (
    .rot_imm (rot_imm),
    .instr   (instr),
    .rm_val  (rm_val),
    .rs_low  (rs_low),
    .src     (src),
    .kind    (kind),
    .cls     (cls),
    .amt     (amt)
  );

  sop_shift_unit #(.DATA_W(DATA_W)) u_unit (
    .src  (src),
    .c_in (c_in),
    .kind (kind),
    .cls  (cls),
    .amt  (amt),
    .val  (unit_val),
    .cout (unit_c)
  );

  logic [DATA_W-1:0] op_q, op_d;
  logic              c_q, c_d;

  always_comb begin
    op_d = op_q;
    c_d  = c_q;
    if (en) begin
      op_d = unit_val;
      c_d  = unit_c;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_q <= '0;
      c_q  <= 1'b0;
    end else begin
      op_q <= op_d;
      c_q  <= c_d;
    end
  end

  assign op_out = op_q;
  assign c_out  = c_q;
endmodule

// File: rtl/sop_checker.sv
module sop_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              rot_imm,
  input logic [11:0]       instr,
  input logic [DATA_W-1:0] rm_val,
  input logic [7:0]        rs_low,
  input logic              c_in,
  input logic [DATA_W-1:0] op_out,
  input logic              c_out
);
  localparam logic [7:0] W_B = 8'(DATA_W);

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(op_out) && $stable(c_out))); // R2

  AST_LSL_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rot_imm && !instr[4] && instr[6:5] == 2'd0 && instr[11:7] == 5'd0)
    |=> (op_out == $past(rm_val) && c_out == $past(c_in))); // R4

  AST_RRX_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rot_imm && !instr[4] && instr[6:5] == 2'd3 && instr[11:7] == 5'd0)
    |=> (op_out == {$past(c_in), $past(rm_val[DATA_W-1:1])} && c_out == $past(rm_val[0]))); // R5

  AST_LOGIC_OVERSIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rot_imm && instr[4] && !instr[6] && rs_low > W_B)
    |=> (op_out == '0 && !c_out)); // R6

  AST_ASR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rot_imm && instr[4] && instr[6:5] == 2'd2 && rs_low >= W_B)
    |=> (op_out == {DATA_W{$past(rm_val[DATA_W-1])}} && c_out == $past(rm_val[DATA_W-1]))); // R7

  AST_ROR_FULL_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rot_imm && instr[4] && instr[6:5] == 2'd3 && rs_low != 8'd0 && rs_low[4:0] == 5'd0)
    |=> (op_out == $past(rm_val) && c_out == $past(rm_val[DATA_W-1]))); // R8

  AST_CONST_NO_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rot_imm && instr[11:8] == 4'd0)
    |=> (op_out == {{(DATA_W-8){1'b0}}, $past(instr[7:0])} && c_out == $past(c_in))); // R9
endmodule

bind shifter_operand_gen sop_checker #(.DATA_W(DATA_W)) u_sop_checker (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .en      (en),
  .rot_imm (rot_imm),
  .instr   (instr),
  .rm_val  (rm_val),
  .rs_low  (rs_low),
  .c_in    (c_in),
  .op_out  (op_out),
  .c_out   (c_out)
);

// File: tb/tb_shifter_operand_gen.sv
module tb_shifter_operand_gen;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         en;
  logic         rot_imm;
  logic [11:0]  instr;
  logic [W-1:0] rm_val;
  logic [7:0]   rs_low;
  logic         c_in;
  logic [W-1:0] op_out;
  logic         c_out;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  logic [W:0] exp_q[$];
  string      tag_q[$];
  logic [W:0] last_exp;

  always #10 clk = ~clk;

  shifter_operand_gen #(.DATA_W(W)) dut (
    .clk (clk), .rst_n (rst_n), .en (en), .rot_imm (rot_imm), .instr (instr),
    .rm_val (rm_val), .rs_low (rs_low), .c_in (c_in), .op_out (op_out), .c_out (c_out)
  );

  // expected {carry, value}, stepping one bit at a time per the requirements
  function automatic logic [W:0] model(input logic ri, input logic [11:0] ins,
                                       input logic [W-1:0] rm, input logic [7:0] rs,
                                       input logic c);
    logic [W-1:0] v = rm;
    logic         cy = c;
    int           n = 0;
    logic [1:0]   m = ins[6:5];
    if (ri) begin
      v = {24'd0, ins[7:0]};
      n = 2 * int'(ins[11:8]);
      m = 2'd3;
    end else if (ins[4]) begin
      if (m == 2'd3) n = (rs == 8'd0) ? 0 : ((rs[4:0] == 5'd0) ? 32 : int'(rs[4:0]));
      else if (m == 2'd2) n = (rs > 8'd32) ? 32 : int'(rs);
      else n = (rs > 8'd33) ? 33 : int'(rs);
    end else begin
      n = int'(ins[11:7]);
      if (n == 0 && (m == 2'd1 || m == 2'd2)) n = 32;
      if (n == 0 && m == 2'd3) return {rm[0], c, rm[W-1:1]};
    end
    for (int i = 0; i < n; i++) begin
      case (m)
        2'd0: begin cy = v[W-1]; v = {v[W-2:0], 1'b0}; end
        2'd1: begin cy = v[0]; v = {1'b0, v[W-1:1]}; end
        2'd2: begin cy = v[0]; v = {v[W-1], v[W-1:1]}; end
        default: begin cy = v[0]; v = {v[0], v[W-1:1]}; end
      endcase
    end
    return {cy, v};
  endfunction

  function automatic logic [11:0] enc_i(input logic [4:0] a, input logic [1:0] m);
    return {a, m, 1'b0, 4'h3};
  endfunction
  function automatic logic [11:0] enc_r(input logic [1:0] m);
    return {4'h2, 1'b0, m, 1'b1, 4'h3};
  endfunction
  function automatic logic [11:0] enc_c(input logic [3:0] r, input logic [7:0] imm);
    return {r, imm};
  endfunction

  task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual val=%h c=%b expected val=%h c=%b",
               tag, act[W-1:0], act[W], exp[W-1:0], exp[W]);
    end
  endtask

  task automatic drive(input string tag, input logic ri, input logic [11:0] ins,
                       input logic [W-1:0] rm, input logic [7:0] rs, input logic c);
    logic [W:0] e;
    @(negedge clk);
    rot_imm = ri; instr = ins; rm_val = rm; rs_low = rs; c_in = c; en = 1'b1;
    e = model(ri, ins, rm, rs, c);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    last_exp = e;
  endtask

  task automatic idle(input int cycles);
    @(negedge clk);
    en = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  // monitor: pops one expected item per enabled edge
  initial begin
    logic took;
    forever begin
      @(posedge clk);
      took = en && rst_n;
      @(negedge clk);
      if (took && exp_q.size() != 0) begin
        check(tag_q.pop_front(), {c_out, op_out}, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R2: actual=hung expected=finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic string rand_tag(input logic ri, input logic [11:0] ins);
    if (ri) return "R9";
    if (ins[4]) begin
      if (ins[6:5] == 2'd3) return "R8";
      if (ins[6:5] == 2'd2) return "R7";
      return "R6";
    end
    if (ins[11:7] == 5'd0) return (ins[6:5] == 2'd3) ? "R5" : "R4";
    return "R3";
  endfunction

  initial begin
    rst_n = 1'b0; en = 1'b1; rot_imm = 1'b0; instr = 12'hFFF;
    rm_val = 32'hDEAD_BEEF; rs_low = 8'h05; c_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset with enable high", {c_out, op_out}, '0);
    en = 1'b0; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {c_out, op_out}, '0);

    // R3 constant amounts 1..31
    drive("R3 lsl 4",  0, enc_i(5'd4, 2'd0),  32'hF000_000F, 8'd0, 1'b0);
    drive("R3 lsr 1",  0, enc_i(5'd1, 2'd1),  32'h8000_0001, 8'd0, 1'b0);
    drive("R3 asr 31", 0, enc_i(5'd31, 2'd2), 32'h8000_0000, 8'd0, 1'b0);
    drive("R3 ror 8",  0, enc_i(5'd8, 2'd3),  32'h1234_5680, 8'd0, 1'b0);
    drive("R3 lsl 31", 0, enc_i(5'd31, 2'd0), 32'h0000_0002, 8'd0, 1'b1);
    // R4 zero constant amount
    drive("R4 lsl 0",  0, enc_i(5'd0, 2'd0), 32'hA5A5_5A5A, 8'd0, 1'b1);
    drive("R4 lsr 0",  0, enc_i(5'd0, 2'd1), 32'h8000_0000, 8'd0, 1'b0);
    drive("R4 asr 0 neg", 0, enc_i(5'd0, 2'd2), 32'h9000_0000, 8'd0, 1'b0);
    drive("R4 asr 0 pos", 0, enc_i(5'd0, 2'd2), 32'h7FFF_FFFF, 8'd0, 1'b1);
    // R5 rotate through carry
    drive("R5 rrx c1", 0, enc_i(5'd0, 2'd3), 32'h0000_0003, 8'd0, 1'b1);
    drive("R5 rrx c0", 0, enc_i(5'd0, 2'd3), 32'hFFFF_FFFE, 8'd0, 1'b0);
    // R6 register logical
    drive("R6 lsl 0",   0, enc_r(2'd0), 32'h1357_9BDF, 8'd0,   1'b1);
    drive("R6 lsl 5",   0, enc_r(2'd0), 32'h0800_0001, 8'd5,   1'b0);
    drive("R6 lsl 32",  0, enc_r(2'd0), 32'h0000_0001, 8'd32,  1'b0);
    drive("R6 lsl 33",  0, enc_r(2'd0), 32'hFFFF_FFFF, 8'd33,  1'b1);
    drive("R6 lsl 200", 0, enc_r(2'd0), 32'hFFFF_FFFF, 8'd200, 1'b1);
    drive("R6 lsr 31",  0, enc_r(2'd1), 32'hC000_0000, 8'd31,  1'b0);
    drive("R6 lsr 32",  0, enc_r(2'd1), 32'h8000_0000, 8'd32,  1'b0);
    drive("R6 lsr 40",  0, enc_r(2'd1), 32'hFFFF_FFFF, 8'd40,  1'b1);
    // R7 register arithmetic
    drive("R7 asr 31",  0, enc_r(2'd2), 32'h8000_0000, 8'd31,  1'b0);
    drive("R7 asr 32",  0, enc_r(2'd2), 32'h8000_0000, 8'd32,  1'b0);
    drive("R7 asr 255", 0, enc_r(2'd2), 32'hC000_0001, 8'd255, 1'b0);
    drive("R7 asr 100", 0, enc_r(2'd2), 32'h7FFF_FFFF, 8'd100, 1'b1);
    // R8 register rotate
    drive("R8 ror 0",  0, enc_r(2'd3), 32'h8765_4321, 8'd0,  1'b1);
    drive("R8 ror 32", 0, enc_r(2'd3), 32'h8765_4321, 8'd32, 1'b0);
    drive("R8 ror 64", 0, enc_r(2'd3), 32'h0765_4321, 8'd64, 1'b1);
    drive("R8 ror 37", 0, enc_r(2'd3), 32'h0000_0010, 8'd37, 1'b0);
    drive("R8 ror 4",  0, enc_r(2'd3), 32'h0000_000F, 8'd4,  1'b0);
    // R9 rotated constant
    drive("R9 rot 0",  1, enc_c(4'd0, 8'hFF),  32'hFFFF_FFFF, 8'd0, 1'b1);
    drive("R9 rot 1",  1, enc_c(4'd1, 8'h03),  32'h0, 8'd0, 1'b0);
    drive("R9 rot 4",  1, enc_c(4'd4, 8'hFF),  32'h0, 8'd0, 1'b1);
    drive("R9 rot 15", 1, enc_c(4'd15, 8'h81), 32'h0, 8'd0, 1'b0);

    for (int i = 0; i < 400; i++) begin
      logic        ri;
      logic [11:0] ins;
      logic [7:0]  rs;
      ri  = ($urandom_range(0, 3) == 0);
      ins = 12'($urandom);
      case ($urandom_range(0, 4))
        0: rs = 8'd0;
        1: rs = 8'd32;
        2: rs = 8'd33;
        3: rs = 8'($urandom_range(1, 31));
        default: rs = 8'($urandom);
      endcase
      drive(rand_tag(ri, ins), ri, ins, 32'($urandom), rs, 1'($urandom));
    end
    idle(3);

    // R2 hold while disabled
    drive("R2 setup", 0, enc_i(5'd3, 2'd1), 32'hF0F0_F0F0, 8'd0, 1'b1);
    @(negedge clk);
    en = 1'b0; rm_val = 32'h0F0F_0F0F; c_in = 1'b0; instr = enc_i(5'd0, 2'd0);
    repeat (3) @(negedge clk);
    check("R2 hold with en low", {c_out, op_out}, last_exp);

    // R1 mid-run reset
    rst_n = 1'b0;
    #1;
    check("R1 async clear", {c_out, op_out}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive("R3 after reset", 0, enc_i(5'd2, 2'd0), 32'h4000_0001, 8'd0, 1'b0);
    idle(3);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule